// File: doc/BRIEF.md
# Stereo Digital Attenuator with Zero Flags

This block sits on a stereo PCM path in front of a DAC. Each sample pair arrives with a valid strobe. For each channel, the block scales the sample by a gain taken from a 7-bit attenuation code and forces the sample to zero when that channel is muted. The result is registered and sent out one clock later with its own valid strobe. Code 0 passes the sample unchanged. Each higher code lowers the level by about 0.375 dB, and code 127 gives the deepest attenuation.

The block also drives one zero flag per channel for external muting circuitry. Two triggers can raise a flag, and each has its own disable bit. The first trigger is the channel being muted or set to the maximum code. The second is a long run of all-zero input samples on that channel. One polarity bit sets the active level of both flags.

Top module: `stereo_atten`

## Requirements
- R1: `out_valid` is high exactly one clock after each cycle with `in_valid` high. While `in_valid` is low, `out_left` and `out_right` keep their values.
- R2: An attenuation code of 0 passes the signed 24-bit input to the output bit-exact.
- R3: For a code k in 1..127, the output is floor(x * G[k] / 2^18). G is defined by G[0] = 2^18 and G[k] = floor(G[k-1] * 251067 / 2^18), which is about 0.375 dB per step.
- R4: `atten_left` scales only `in_left` and `atten_right` scales only `in_right`. The two codes are independent.
- R5: While `mute_left` (or `mute_right`) is 1 in a strobe cycle, that channel's output is 0. The other channel is unaffected.
- R6: A sample is scaled by the code present in the cycle its strobe is high. A code change between strobes does not alter an output already produced.
- R7: The zero-data condition on a channel becomes true once 1024 consecutive strobed samples on that channel are all zero. A single non-zero sample on that channel clears it.
- R8: While `zf_mv_off` is 0, the channel's flag is active whenever that channel is muted or its code is 127. Setting `zf_mv_off` to 1 removes this trigger.
- R9: While `zf_zd_off` is 0, the channel's flag is active while its zero-data condition holds. Setting `zf_zd_off` to 1 removes this trigger.
- R10: When `zf_pol` is 0, an active flag reads 1 and an inactive flag reads 0. When `zf_pol` is 1, both levels are inverted. The flags are registered and follow the controls one clock later.
- R11: While `rst` is high, `out_valid`, `out_left`, `out_right`, `zflag_left` and `zflag_right` are 0, and the zero-run counters are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample pair strobe |
| in_left | input | 24 | Left sample, signed |
| in_right | input | 24 | Right sample, signed |
| atten_left | input | 7 | Left attenuation code |
| atten_right | input | 7 | Right attenuation code |
| mute_left | input | 1 | Left mute |
| mute_right | input | 1 | Right mute |
| zf_mv_off | input | 1 | Disable the mute / maximum-code flag trigger |
| zf_zd_off | input | 1 | Disable the zero-data flag trigger |
| zf_pol | input | 1 | Flag polarity, 1 selects active low |
| out_valid | output | 1 | Output pair strobe |
| out_left | output | 24 | Left result, signed |
| out_right | output | 24 | Right result, signed |
| zflag_left | output | 1 | Left zero flag |
| zflag_right | output | 1 | Right zero flag |

## Verification
The assertions assume that the samples, codes and mute bits are settled in the cycle their strobe is high. They also assume the flag controls are steady for at least one clock before a flag is checked, because the flag registers sample them every cycle. The stimulus changes all inputs half a period away from the active edge. It holds the controls for several idle cycles before each flag check, and it applies zero runs of exactly 1023 and 1024 samples to reach both sides of the threshold.

// File: rtl/atten_pkg.sv
package atten_pkg;
    localparam int SAMPLE_W  = 24;
    localparam int CODE_W    = 7;
    localparam int N_CODES   = 1 << CODE_W;
    localparam int GAIN_W    = 18;
    localparam longint STEP_MULT = 251067;  // 10^(-0.375/20) scaled by 2^18
    localparam int ZERO_RUN  = 1024;
    localparam int N_CH      = 2;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [CODE_W-1:0]          code_t;
    typedef logic [GAIN_W-1:0]          gain_t;

    typedef struct packed {
        sample_t smp;
        code_t   code;
        logic    mute;
    } ch_in_t;

    // Gain for code k: repeated scaling of unity by the step factor.
    function automatic longint gain_of(input int k);
        longint g = longint'(1) << GAIN_W;
        for (int i = 1; i < k; i++) begin
            g = (g * STEP_MULT) >> GAIN_W;
        end
        if (k >= 1) g = (g * STEP_MULT) >> GAIN_W;
        return g;
    endfunction
endpackage

// File: rtl/atten_gain_rom.sv
module atten_gain_rom
    import atten_pkg::*;
#(
    parameter int CW = CODE_W,
    parameter int GW = GAIN_W
) (
    input  logic [CW-1:0] code,
    output logic [GW-1:0] gain
);
    localparam int DEPTH = 1 << CW;

    logic [GW-1:0] rom [DEPTH];

    // Entry 0 holds unity, which does not fit; it is never used (bypass path).
    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        localparam longint VAL = gain_of(g);
        assign rom[g] = VAL[GW-1:0];
    end

    assign gain = rom[code];
endmodule

// File: rtl/atten_channel.sv
module atten_channel
    import atten_pkg::*;
#(
    parameter int DW = SAMPLE_W,
    parameter int CW = CODE_W,
    parameter int GW = GAIN_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] smp_i,
    input  logic [CW-1:0]        code_i,
    input  logic                 mute_i,
    output logic signed [DW-1:0] smp_o
);
    localparam int PW = DW + GW + 1;

    logic [GW-1:0]        gain;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shifted;
    logic signed [DW-1:0] scaled;

    atten_gain_rom #(.CW(CW), .GW(GW)) u_rom (
        .code (code_i),
        .gain (gain)
    );

    always_comb begin
        prod    = PW'(smp_i) * PW'($signed({1'b0, gain}));
        shifted = prod >>> GW;
        if (mute_i)
            scaled = '0;
        else if (code_i == '0)
            scaled = smp_i;
        else
            scaled = shifted[DW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            smp_o <= '0;
        else if (in_valid)
            smp_o <= scaled;
    end

    p_mute_zero_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && mute_i |=> smp_o == '0);
    p_bypass_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && !mute_i && code_i == '0 |=> smp_o == $past(smp_i));
    p_no_gain_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid && !mute_i && !smp_i[DW-1] |=> !smp_o[DW-1] && smp_o <= $past(smp_i));
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(smp_o));
endmodule

// File: rtl/zero_run_detect.sv
module zero_run_detect
    import atten_pkg::*;
#(
    parameter int DW  = SAMPLE_W,
    parameter int RUN = ZERO_RUN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] smp_i,
    output logic          zero_o
);
    localparam int CNTW = $clog2(RUN + 1);

    logic [CNTW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (in_valid) begin
            if (smp_i != '0)
                cnt <= '0;
            else if (cnt != CNTW'(RUN))
                cnt <= cnt + 1'b1;
        end
    end

    assign zero_o = (cnt == CNTW'(RUN));

    p_clear_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && smp_i != '0 |=> !zero_o && cnt == '0);
    p_count_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && smp_i == '0 && cnt != CNTW'(RUN) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
    import atten_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    input  logic [CODE_W-1:0]          atten_left,
    input  logic [CODE_W-1:0]          atten_right,
    input  logic                       mute_left,
    input  logic                       mute_right,
    input  logic                       zf_mv_off,
    input  logic                       zf_zd_off,
    input  logic                       zf_pol,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right,
    output logic                       zflag_left,
    output logic                       zflag_right
);
    ch_in_t                    ch_in  [N_CH];
    logic signed [SAMPLE_W-1:0] ch_out [N_CH];
    logic [N_CH-1:0]           zdata;
    logic [N_CH-1:0]           zflag;

    assign ch_in[0] = '{smp: in_left,  code: atten_left,  mute: mute_left};
    assign ch_in[1] = '{smp: in_right, code: atten_right, mute: mute_right};

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic active;

        atten_channel u_chan (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .smp_i    (ch_in[c].smp),
            .code_i   (ch_in[c].code),
            .mute_i   (ch_in[c].mute),
            .smp_o    (ch_out[c])
        );

        zero_run_detect u_zrun (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .smp_i    (ch_in[c].smp),
            .zero_o   (zdata[c])
        );

        always_comb begin
            active = (!zf_mv_off && (ch_in[c].mute || ch_in[c].code == code_t'(N_CODES - 1)))
                  || (!zf_zd_off && zdata[c]);
        end

        always_ff @(posedge clk) begin
            if (rst)
                zflag[c] <= 1'b0;
            else
                zflag[c] <= active ^ zf_pol;
        end

        p_mute_flag_r8: assert property (@(posedge clk) disable iff (rst)
            !zf_mv_off && ch_in[c].mute |=> zflag[c] == !$past(zf_pol));
        p_zero_flag_r9: assert property (@(posedge clk) disable iff (rst)
            !zf_zd_off && zdata[c] |=> zflag[c] == !$past(zf_pol));
    end

    always_ff @(posedge clk) begin
        if (rst)
            out_valid <= 1'b0;
        else
            out_valid <= in_valid;
    end

    assign out_left    = ch_out[0];
    assign out_right   = ch_out[1];
    assign zflag_left  = zflag[0];
    assign zflag_right = zflag[1];

    p_valid_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
endmodule

// File: tb/stereo_atten_tb.sv
module stereo_atten_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [23:0] in_left = '0, in_right = '0;
    logic [6:0] atten_left = '0, atten_right = '0;
    logic mute_left = 1'b0, mute_right = 1'b0;
    logic zf_mv_off = 1'b0, zf_zd_off = 1'b0, zf_pol = 1'b0;
    logic out_valid;
    logic signed [23:0] out_left, out_right;
    logic zflag_left, zflag_right;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stereo_atten u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_left(in_left), .in_right(in_right),
        .atten_left(atten_left), .atten_right(atten_right),
        .mute_left(mute_left), .mute_right(mute_right),
        .zf_mv_off(zf_mv_off), .zf_zd_off(zf_zd_off), .zf_pol(zf_pol),
        .out_valid(out_valid), .out_left(out_left), .out_right(out_right),
        .zflag_left(zflag_left), .zflag_right(zflag_right)
    );

    function automatic longint ref_gain(input int k);
        longint g = 262144;
        for (int i = 0; i < k; i++) g = (g * 251067) >>> 18;
        return g;
    endfunction

    function automatic longint ref_out(input longint x, input int k, input bit m);
        if (m) return 0;
        if (k == 0) return x;
        return (x * ref_gain(k)) >>> 18;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic signed [23:0] l, input logic signed [23:0] r);
        in_left = l; in_right = r; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
    endtask

    // {left, right, code_l, code_r, mute_l, mute_r}
    localparam int NV = 9;
    localparam logic [63:0] VEC [NV] = '{
        {24'sd1000000,  24'sd1000000,  7'd0,   7'd0,   1'b0, 1'b0},
        {-24'sd1000000, 24'sd4194303,  7'd1,   7'd16,  1'b0, 1'b0},
        {24'sd8388607,  -24'sd8388608, 7'd127, 7'd127, 1'b0, 1'b0},
        {-24'sd1,       24'sd1,        7'd5,   7'd5,   1'b0, 1'b0},
        {24'sd7000000,  -24'sd3333333, 7'd64,  7'd2,   1'b0, 1'b0},
        {24'sd123456,   24'sd123456,   7'd0,   7'd0,   1'b1, 1'b0},
        {-24'sd8388608, 24'sd5555555,  7'd40,  7'd100, 1'b0, 1'b1},
        {24'sd2500000,  24'sd2500000,  7'd127, 7'd0,   1'b0, 1'b0},
        {-24'sd777,     24'sd8388607,  7'd3,   7'd126, 1'b0, 1'b0}
    };

    initial begin
        // R11 reset state
        idle(2);
        check("R11 out_valid", out_valid, 0);
        check("R11 out_left", out_left, 0);
        check("R11 zflag", {zflag_left, zflag_right}, 0);
        rst = 1'b0;
        idle(1);

        // Vector table: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            logic signed [23:0] vl, vr;
            int cl, cr;
            bit ml, mr;
            vl = VEC[i][63:40]; vr = VEC[i][39:16];
            cl = int'(VEC[i][15:9]); cr = int'(VEC[i][8:2]);
            ml = VEC[i][1]; mr = VEC[i][0];
            atten_left = 7'(cl); atten_right = 7'(cr);
            mute_left = ml; mute_right = mr;
            send(vl, vr);
            check("R1 out_valid", out_valid, 1);
            check("R3/R4/R5 left", out_left, ref_out(vl, cl, ml));
            check("R3/R4/R5 right", out_right, ref_out(vr, cr, mr));
        end
        mute_left = 1'b0; mute_right = 1'b0;

        // R1 hold and R6 code change between strobes
        atten_left = 7'd10; atten_right = 7'd0;
        send(24'sd3000000, -24'sd3000000);
        atten_left = 7'd90; atten_right = 7'd50;
        idle(2);
        check("R1 idle valid", out_valid, 0);
        check("R6 left kept", out_left, ref_out(3000000, 10, 0));
        check("R6 right kept", out_right, -3000000);
        check("R2 exact", out_right, -3000000);

        // R7 zero run, R9 trigger
        do_reset();
        atten_left = 7'd0; atten_right = 7'd0;
        for (int i = 0; i < 1023; i++) send(24'sd0, 24'sd5);
        idle(2);
        check("R7 1023 zeros", zflag_left, 0);
        send(24'sd0, 24'sd5);
        idle(2);
        check("R7 1024 zeros", zflag_left, 1);
        check("R7 right nonzero", zflag_right, 0);
        zf_zd_off = 1'b1;
        idle(2);
        check("R9 disabled", zflag_left, 0);
        zf_zd_off = 1'b0;
        idle(2);
        check("R9 enabled", zflag_left, 1);
        send(24'sd1, 24'sd5);
        idle(2);
        check("R7 cleared", zflag_left, 0);

        // R8 mute / max code trigger, R10 polarity
        mute_left = 1'b1;
        idle(2);
        check("R8 mute flag", zflag_left, 1);
        zf_pol = 1'b1;
        idle(2);
        check("R10 active low", zflag_left, 0);
        check("R10 inactive high", zflag_right, 1);
        zf_mv_off = 1'b1;
        idle(2);
        check("R8 disabled", zflag_left, 1);
        zf_mv_off = 1'b0; zf_pol = 1'b0; mute_left = 1'b0;
        atten_right = 7'd127;
        idle(2);
        check("R8 max code", zflag_right, 1);
        check("R8 left idle", zflag_left, 0);
        atten_right = 7'd126;
        idle(2);
        check("R8 code 126", zflag_right, 0);

        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule